// File: doc/BRIEF.md
# Unrolled Multi-Mode CORDIC Pipeline

This block evaluates the CORDIC recurrences as a fully unrolled array. Every microrotation is one registered stage, so the block accepts one new sample per clock and returns one result per clock after a fixed latency. Each sample carries its own coordinate-system select and its own operating-mode select. As a result, circular, linear and hyperbolic work can be interleaved freely, in either rotation or vectoring mode.

Inputs x, y and z are N-bit two's complement values. x and y are plain integers. z has N-3 fractional bits and means radians in the circular and hyperbolic systems, or a plain ratio in the linear system. Inside, the x/y path carries ceil(log2 N) guard bits below the input LSB and three extra bits above it. The z path carries ceil(log2(N/3)) guard bits and four extra bits above. The outputs drop the guard bits by truncation. The results carry the raw CORDIC gain: the block does no scale compensation.

Top module: `cordic_pipe`

## Requirements
- R1: Circular rotation (coord 2'b00, vec_mode 0) gives x_out ≈ Kc·(x·cos z − y·sin z) and y_out ≈ Kc·(y·cos z + x·sin z), with Kc = ∏ sqrt(1+2^(−2s)) over s = 0..N−1. z_out ≈ 0. This holds for |z| ≤ 1.5.
- R2: Circular vectoring (coord 2'b00, vec_mode 1) with x > 0 gives x_out ≈ Kc·sqrt(x²+y²), y_out ≈ 0 and z_out ≈ z + atan(y/x).
- R3: Linear rotation (coord 2'b01, vec_mode 0) gives y_out ≈ y + x·z and z_out ≈ 0, for |z| ≤ 1.5.
- R4: Linear vectoring (coord 2'b01, vec_mode 1) gives z_out ≈ z + y/x and y_out ≈ 0, for |y/x| ≤ 1.5.
- R5: Hyperbolic work (coord 2'b10) gives the following. In rotation mode: x_out ≈ Kh·(x·cosh z + y·sinh z) and y_out ≈ Kh·(y·cosh z + x·sinh z). In vectoring mode: x_out ≈ Kh·sqrt(x²−y²) and z_out ≈ z + atanh(y/x). These hold for |z| ≤ 1 and |y| < 0.7·x.
- R6: The hyperbolic stages use shifts 1..N in order, with every shift of the form 3k+1 (4, 13, 40, …) up to N applied twice. So Kh = ∏ sqrt(1−2^(−2s)) over that sequence, and the array has N plus that number of repeats stages (18 for N = 16).
- R7: A zero value is treated as positive when a direction is decided. Rotation with z = 0 and vectoring with y = 0 still meet R1 and R2.
- R8: out_valid rises exactly as many cycles after in_valid as there are stages. Each accepted sample yields exactly one result, in issue order.
- R9: The coordinate and mode selects travel with each sample. Back-to-back samples with different settings are each computed by their own settings.
- R10: During reset and after it, out_valid stays low until a sample has passed the whole array.
- R11: In the linear system, x_out equals x exactly.
- R12: In circular vectoring with x ≥ 0, no stage lowers x.
- R13: Each direction is decided as follows. In rotation mode, σ = +1 when z ≥ 0 and −1 otherwise, so a non-negative z strictly decreases at an active stage. In vectoring mode, σ = −1 when x and y have equal sign bits and +1 otherwise, which drives y toward zero.
- R14: Coord code 2'b11 behaves exactly as the linear system.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| coord_sel | input | 2 | 00 circular, 01 linear, 10 hyperbolic, 11 linear |
| vec_mode | input | 1 | 0 rotation, 1 vectoring |
| x_in | input | N | x start value, two's complement |
| y_in | input | N | y start value, two's complement |
| z_in | input | N | z start value, N−3 fractional bits |
| out_valid | output | 1 | Result strobe |
| x_out | output | N+3 | x result, input units |
| y_out | output | N+3 | y result, input units |
| z_out | output | N+4 | z result, N−3 fractional bits |

## Verification
The bench aims at the following corner cases:
- **Zero inputs.** It issues z = 0 in rotation and y = 0 in vectoring. A design that took a zero as "no rotation" or picked the wrong sign would leave the gain off and miss R1 and R2 by thousands of LSBs.
- **Hyperbolic schedule.** Hyperbolic results are compared against a gain that includes the repeated shifts 4 and 13. A schedule that omitted or misplaced a repeat would fail to converge or would show a gain error.
- **Mixed traffic.** Samples with differing coordinate and mode settings are streamed back to back, with code 2'b11 among them. A design that sampled the selects once, or decoded 2'b11 as another system, would corrupt its neighbours.
- **Latency and the linear x path.** Latency is counted per sample and linear x_out is compared exactly. An extra pipeline register or a stray update on the linear x path is therefore visible.

// File: rtl/cordic_pkg.sv
// Shared types and elaboration-time helpers for the CORDIC pipeline.
// Assumes constant functions are evaluated at elaboration only.
package cordic_pkg;

    // Coordinate-system code carried with each sample; 2'b11 acts as linear.
    typedef enum logic [1:0] {
        CRD_CIRC = 2'b00,
        CRD_LIN  = 2'b01,
        CRD_HYP  = 2'b10,
        CRD_ALT  = 2'b11
    } coord_e;

    // Shift used by hyperbolic stage idx: 1,2,3,4,4,5,...,13,13,14,...
    function automatic int hyp_shift(int idx);
        int s;
        int rep;
        bit used;
        s    = 1;
        rep  = 4;
        used = 1'b0;
        for (int c = 0; c < idx; c++) begin
            if (s == rep && !used) begin
                used = 1'b1;
            end else begin
                if (s == rep) rep = 3 * rep + 1;
                s    = s + 1;
                used = 1'b0;
            end
        end
        return s;
    endfunction

    // Number of repeated hyperbolic shifts (3k+1 values) not above n.
    function automatic int hyp_repeats(int n);
        int cnt;
        int k;
        cnt = 0;
        k   = 4;
        while (k <= n) begin
            cnt = cnt + 1;
            k   = 3 * k + 1;
        end
        return cnt;
    endfunction

    // Power series of atan (alt=1) or atanh (alt=0) for |t| <= 0.5.
    function automatic real arc_series(real t, bit alt);
        real sum;
        real p;
        sum = 0.0;
        p   = t;
        for (int k = 0; k < 40; k++) begin
            if (alt && (k % 2 == 1)) sum = sum - p / real'(2 * k + 1);
            else                     sum = sum + p / real'(2 * k + 1);
            p = p * t * t;
        end
        return sum;
    endfunction

    // Stage angle for shift s, rounded to fz fractional bits.
    function automatic int angle_fix(coord_e c, int s, int fz);
        real t;
        real a;
        real sc;
        t  = 1.0;
        sc = 1.0;
        for (int k = 0; k < s; k++)  t  = t / 2.0;
        for (int k = 0; k < fz; k++) sc = sc * 2.0;
        case (c)
            CRD_CIRC: a = (s == 0) ? 0.78539816339744831 : arc_series(t, 1'b1);
            CRD_HYP:  a = arc_series(t, 1'b0);
            default:  a = t;
        endcase
        return $rtoi(a * sc + 0.5);
    endfunction

endpackage

// File: rtl/cordic_dir.sv
// Direction decision for one microrotation.
// Assumes sign bits of the stage inputs; a zero value counts as positive.
// neg = 1 selects sigma = -1, neg = 0 selects sigma = +1.
module cordic_dir (
    input  logic vec,
    input  logic x_neg,
    input  logic y_neg,
    input  logic z_neg,
    output logic neg
);

    // Rotation follows the sign of z; vectoring opposes the sign of x*y.
    always_comb begin
        if (vec) neg = ~(x_neg ^ y_neg);
        else     neg = z_neg;
    end

endmodule

// File: rtl/cordic_stage.sv
// One registered microrotation of the unrolled array.
// Stage IDX uses shift IDX for circular/linear (and passes data through
// when IDX >= N), and the repeated hyperbolic schedule otherwise.
// Assumes inputs already carry the guard and overflow bits.
module cordic_stage
    import cordic_pkg::*;
#(
    parameter int IDX = 0,
    parameter int N   = 16,
    parameter int WXY = 23,
    parameter int WZ  = 23,
    parameter int FZ  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vld_i,
    input  coord_e                coord_i,
    input  logic                  vec_i,
    input  logic signed [WXY-1:0] x_i,
    input  logic signed [WXY-1:0] y_i,
    input  logic signed [WZ-1:0]  z_i,
    output logic                  vld_q,
    output coord_e                coord_q,
    output logic                  vec_q,
    output logic signed [WXY-1:0] x_q,
    output logic signed [WXY-1:0] y_q,
    output logic signed [WZ-1:0]  z_q
);

    localparam bit BYPASS = (IDX >= N);
    localparam int SH_C   = (IDX < WXY) ? IDX : WXY - 1;
    localparam int SH_H0  = hyp_shift(IDX);
    localparam int SH_H   = (SH_H0 < WXY) ? SH_H0 : WXY - 1;
    localparam logic signed [WZ-1:0] A_C = WZ'(angle_fix(CRD_CIRC, SH_C, FZ));
    localparam logic signed [WZ-1:0] A_L = WZ'(angle_fix(CRD_LIN,  SH_C, FZ));
    localparam logic signed [WZ-1:0] A_H = WZ'(angle_fix(CRD_HYP,  SH_H, FZ));

    logic                  is_circ, is_hyp, idle, neg;
    logic signed [WXY-1:0] xs, ys, x_n, y_n;
    logic signed [WZ-1:0]  alpha, z_n;

    cordic_dir u_dir (
        .vec   (vec_i),
        .x_neg (x_i[WXY-1]),
        .y_neg (y_i[WXY-1]),
        .z_neg (z_i[WZ-1]),
        .neg   (neg)
    );

    // Decode the sample's coordinate system; code 2'b11 falls to linear.
    always_comb begin
        is_circ = (coord_i == CRD_CIRC);
        is_hyp  = (coord_i == CRD_HYP);
        idle    = BYPASS && !is_hyp;
    end

    // Shift the operands and pick the stage angle for this system.
    always_comb begin
        xs    = is_hyp ? (x_i >>> SH_H) : (x_i >>> SH_C);
        ys    = is_hyp ? (y_i >>> SH_H) : (y_i >>> SH_C);
        alpha = is_circ ? A_C : (is_hyp ? A_H : A_L);
    end

    // Microrotation: x gets -m*sigma*ys, y gets sigma*xs, z gets -sigma*alpha.
    always_comb begin
        y_n = neg ? (y_i - xs) : (y_i + xs);
        z_n = neg ? (z_i + alpha) : (z_i - alpha);
        if (is_circ)     x_n = neg ? (x_i + ys) : (x_i - ys);
        else if (is_hyp) x_n = neg ? (x_i - ys) : (x_i + ys);
        else             x_n = x_i;
        if (idle) begin
            x_n = x_i;
            y_n = y_i;
            z_n = z_i;
        end
    end

    // Valid strobe register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_i;
    end

    // Data registers load only when a sample is present.
    always_ff @(posedge clk) begin
        if (vld_i) begin
            coord_q <= coord_i;
            vec_q   <= vec_i;
            x_q     <= x_n;
            y_q     <= y_n;
            z_q     <= z_n;
        end
    end

    // The linear system never alters x.
    p_lin_x_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i && !is_circ && !is_hyp |=> x_q == $past(x_i));

    // Vectoring with equal signs of x and y must choose sigma = -1.
    p_vec_dir_r13: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i && vec_i && (x_i[WXY-1] == y_i[WXY-1]) |-> neg);

    // Rotation on non-negative z at an active stage lowers z.
    p_rot_z_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i && !vec_i && !z_i[WZ-1] && !idle |=> z_q < $past(z_i));

    // Circular vectoring from non-negative x never shrinks x.
    p_circ_vec_x_grow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i && vec_i && is_circ && !x_i[WXY-1] && !idle |=> x_q >= $past(x_i));

    // Stages past the circular/linear count pass those samples unchanged.
    if (BYPASS) begin : g_byp_chk
        p_byp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            vld_i && !is_hyp |=> x_q == $past(x_i) && y_q == $past(y_i) && z_q == $past(z_i));
    end

endmodule

// File: rtl/cordic_pipe.sv
// Top of the unrolled CORDIC array: widens the inputs with guard and
// overflow bits, chains the stages, and truncates the guard bits on output.
// Assumes inputs inside the convergence region of the chosen system.
module cordic_pipe
    import cordic_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          coord_sel,
    input  logic                vec_mode,
    input  logic signed [N-1:0] x_in,
    input  logic signed [N-1:0] y_in,
    input  logic signed [N-1:0] z_in,
    output logic                out_valid,
    output logic signed [N+2:0] x_out,
    output logic signed [N+2:0] y_out,
    output logic signed [N+3:0] z_out
);

    localparam int G   = $clog2(N);
    localparam int GZ  = $clog2(N / 3);
    localparam int WXY = N + G + 3;
    localparam int WZ  = N + GZ + 4;
    localparam int FZ  = N - 3 + GZ;
    localparam int NS  = N + hyp_repeats(N);

    logic                  vld   [0:NS];
    coord_e                crd   [0:NS];
    logic                  vec   [0:NS];
    logic signed [WXY-1:0] xv    [0:NS];
    logic signed [WXY-1:0] yv    [0:NS];
    logic signed [WZ-1:0]  zv    [0:NS];

    // Widen the inputs: sign extension above, zero guard bits below.
    always_comb begin
        vld[0] = in_valid;
        crd[0] = coord_e'(coord_sel);
        vec[0] = vec_mode;
        xv[0]  = {{3{x_in[N-1]}}, x_in, {G{1'b0}}};
        yv[0]  = {{3{y_in[N-1]}}, y_in, {G{1'b0}}};
        zv[0]  = {{4{z_in[N-1]}}, z_in, {GZ{1'b0}}};
    end

    for (genvar j = 0; j < NS; j++) begin : g_stage
        cordic_stage #(
            .IDX (j),
            .N   (N),
            .WXY (WXY),
            .WZ  (WZ),
            .FZ  (FZ)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld_i   (vld[j]),
            .coord_i (crd[j]),
            .vec_i   (vec[j]),
            .x_i     (xv[j]),
            .y_i     (yv[j]),
            .z_i     (zv[j]),
            .vld_q   (vld[j+1]),
            .coord_q (crd[j+1]),
            .vec_q   (vec[j+1]),
            .x_q     (xv[j+1]),
            .y_q     (yv[j+1]),
            .z_q     (zv[j+1])
        );
    end

    // Drop the guard bits of the last stage (truncation).
    always_comb begin
        out_valid = vld[NS];
        x_out     = xv[NS][WXY-1:G];
        y_out     = yv[NS][WXY-1:G];
        z_out     = zv[NS][WZ-1:GZ];
    end

endmodule

// File: tb/cordic_pipe_tb.sv
module cordic_pipe_tb;

    localparam int  N      = 16;
    localparam int  LAT    = 18;
    localparam real ZS     = 8192.0;
    localparam int  DEPTH  = 1024;
    localparam int  LIMIT  = 20000;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [1:0]          coord_sel = 2'b00;
    logic                vec_mode = 1'b0;
    logic signed [N-1:0] x_in = '0;
    logic signed [N-1:0] y_in = '0;
    logic signed [N-1:0] z_in = '0;
    logic                out_valid;
    logic signed [N+2:0] x_out;
    logic signed [N+2:0] y_out;
    logic signed [N+3:0] z_out;

    cordic_pipe #(.N(N)) u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .coord_sel (coord_sel), .vec_mode (vec_mode),
        .x_in (x_in), .y_in (y_in), .z_in (z_in),
        .out_valid (out_valid), .x_out (x_out), .y_out (y_out), .z_out (z_out)
    );

    always #2 clk = ~clk;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    wr = 0;
    int    rd = 0;
    real   kc, kh;
    real   ex [0:DEPTH-1];
    real   ey [0:DEPTH-1];
    real   ez [0:DEPTH-1];
    real   tx [0:DEPTH-1];
    int    t_iss [0:DEPTH-1];
    string tag [0:DEPTH-1];

    always @(posedge clk) cyc++;

    task automatic chk(string t, real act, real exp, real tol);
        checks++;
        if ((act - exp > tol) || (exp - act > tol)) begin
            errors++;
            $display("FAIL %s: actual %0f expected %0f", t, act, exp);
        end
    endtask

    // Compare each result against its expectation as it leaves the array.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd >= wr) begin
                chk("R8 unexpected result", 1.0, 0.0, 0.0);
            end else begin
                chk({tag[rd], " x"}, $itor(x_out), ex[rd], tx[rd]);
                chk({tag[rd], " y"}, $itor(y_out), ey[rd], 8.0);
                chk({tag[rd], " z"}, $itor(z_out), ez[rd], 8.0);
                chk("R8 latency", $itor(cyc - t_iss[rd]), $itor(LAT), 0.0);
                rd++;
            end
        end
    end

    // Issue one sample and record what the requirements predict for it.
    task automatic issue(int x, int y, int z, int crd, bit vm, string t);
        real xr, yr, zr;
        xr = $itor(x);
        yr = $itor(y);
        zr = $itor(z) / ZS;
        tx[wr] = 8.0;
        case (crd)
            0: if (!vm) begin  // R1
                   ex[wr] = kc * (xr * $cos(zr) - yr * $sin(zr));
                   ey[wr] = kc * (yr * $cos(zr) + xr * $sin(zr));
                   ez[wr] = 0.0;
               end else begin  // R2 R12 R13
                   ex[wr] = kc * $sqrt(xr * xr + yr * yr);
                   ey[wr] = 0.0;
                   ez[wr] = (zr + $atan(yr / xr)) * ZS;
               end
            2: if (!vm) begin  // R5 R6
                   ex[wr] = kh * (xr * $cosh(zr) + yr * $sinh(zr));
                   ey[wr] = kh * (yr * $cosh(zr) + xr * $sinh(zr));
                   ez[wr] = 0.0;
               end else begin
                   ex[wr] = kh * $sqrt(xr * xr - yr * yr);
                   ey[wr] = 0.0;
                   ez[wr] = (zr + $atanh(yr / xr)) * ZS;
               end
            default: begin  // R3 R4 R11 R14: linear, x exact
                   ex[wr] = xr;
                   tx[wr] = 0.0;
                   if (!vm) begin
                       ey[wr] = yr + xr * zr;
                       ez[wr] = 0.0;
                   end else begin
                       ey[wr] = 0.0;
                       ez[wr] = (zr + yr / xr) * ZS;
                   end
               end
        endcase
        tag[wr] = t;
        @(negedge clk);
        in_valid  = 1'b1;
        coord_sel = crd[1:0];
        vec_mode  = vm;
        x_in      = N'(x);
        y_in      = N'(y);
        z_in      = N'(z);
        t_iss[wr] = cyc;
        wr++;
    endtask

    task automatic idle_one();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic int rr(int lo, int hi);
        return lo + int'($urandom % 32'(hi - lo + 1));
    endfunction

    // One random sample of the given kind inside its convergence region.
    task automatic random_one(int kind);
        int x, y;
        case (kind)
            0: issue(rr(-8000, 8000), rr(-8000, 8000), rr(-12288, 12288), 0, 1'b0, "R1/R9 circ rot");
            1: issue(rr(2048, 8000), rr(-8000, 8000), rr(-4096, 4096), 0, 1'b1, "R2/R12/R13 circ vec");
            2: issue(rr(-8000, 8000), rr(-8000, 8000), rr(-12288, 12288), 1, 1'b0, "R3/R11/R9 lin rot");
            3: begin
                   x = rr(2048, 8000);
                   if (rr(0, 1) == 1) x = -x;
                   y = rr(-8000, 8000);
                   if (y > x + x / 2 || y < -(x + x / 2)) y = y / 2;
                   if (y > 1.5 * $itor(x) || -y > 1.5 * $itor(x)) y = 0;
                   if (x < 0 && (y > -(x + x / 2) || y < x + x / 2)) y = y / 4;
                   issue(x, y, rr(-8192, 8192), 1, 1'b1, "R4/R11/R13 lin vec");
               end
            4: issue(rr(-8000, 8000), rr(-8000, 8000), rr(-8192, 8192), 2, 1'b0, "R5/R6 hyp rot");
            5: begin
                   x = rr(3000, 8000);
                   y = rr(-(x * 7) / 10, (x * 7) / 10);
                   issue(x, y, rr(-4096, 4096), 2, 1'b1, "R5/R6/R13 hyp vec");
               end
            default: issue(rr(-8000, 8000), rr(-8000, 8000), rr(-12288, 12288), 3, 1'b0, "R14 alt code");
        endcase
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20240611);
        kc = 1.0;
        for (int s = 0; s < N; s++) kc = kc * $sqrt(1.0 + $pow(2.0, -2.0 * s));
        kh = 1.0;
        for (int s = 1; s <= N; s++) begin
            kh = kh * $sqrt(1.0 - $pow(2.0, -2.0 * s));
            if (s == 4 || s == 13) kh = kh * $sqrt(1.0 - $pow(2.0, -2.0 * s));
        end

        // R10: no result strobe during reset or on an empty array after it.
        repeat (4) @(negedge clk);
        chk("R10 valid in reset", $itor(out_valid), 0.0, 0.0);
        rst_n = 1'b1;
        repeat (LAT + 3) @(negedge clk);
        chk("R10 valid after reset", $itor(out_valid), 0.0, 0.0);

        // Directed corners.
        issue(5000, -3000, 0, 0, 1'b0, "R7 zero z circ rot");
        issue(6000, 0, 0, 0, 1'b1, "R7 zero y circ vec");
        issue(6000, 0, 1000, 2, 1'b1, "R7/R5 zero y hyp vec");
        issue(8000, 8000, 0, 0, 1'b1, "R2 diagonal");
        issue(7000, 2000, 12288, 1, 1'b0, "R3 large z");
        issue(-4000, 6000, 0, 1, 1'b1, "R4 negative x");
        issue(4000, 2000, 8192, 2, 1'b0, "R5 z one");
        issue(7000, -3000, -8192, 3, 1'b0, "R14 alt code");
        issue(5000, 1000, 0, 3, 1'b1, "R14 alt code vec");
        idle_one();

        // Mixed random stream, mostly back to back, with occasional gaps.
        for (int i = 0; i < 320; i++) begin
            random_one(rr(0, 6));
            if (rr(0, 9) == 0) idle_one();
        end
        idle_one();

        while (rd < wr && cyc < LIMIT) @(negedge clk);
        if (rd < wr) chk("R8 watchdog drained", $itor(rd), $itor(wr), 0.0);
        repeat (LAT + 2) @(negedge clk);
        chk("R9 result count", $itor(rd), $itor(wr), 0.0);
        chk("R10 idle after drain", $itor(out_valid), 0.0, 0.0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure and still reports.
    initial begin
        wait (cyc >= LIMIT + 1000);
        chk("R8 watchdog", 1.0, 0.0, 0.0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule